// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external host read and write a small bank of 16-bit configuration registers over a slow serial link. The host pulls the active-low select low, clocks in an 8-bit instruction and then moves one 16-bit word. The instruction holds a direction flag and a 7-bit register address. The block hands the register contents to the rest of the chip as one flat vector.

The link pins are brought into the fast core clock domain through two-flop synchronizers, and all edge detection is done there. The serial clock must therefore stay well below a quarter of the core clock rate. One register bit selects the pin arrangement. In three-pin mode read data leaves on the shared data line, and a pad output enable is raised for the data phase only. In four-pin mode read data leaves on a dedicated output pin, and the shared line stays an input.

Top module: `srp_port`

## Requirements
- R1: While the select is high, the frame state is cleared, `sdio_oe_o` is 0 and `sdo_o` is 0.
- R2: The first 8 bits of a frame form the instruction, sent most significant bit first. Bit 7 set to 1 means read and 0 means write, and bits 6..0 are the register address. A read frame never changes a register, whatever arrives on the data line during its data phase.
- R3: In a write frame, the next 16 bits, most significant first, are stored into the addressed register once the 16th data bit has been sampled on a rising serial clock edge.
- R4: A write frame that ends before its 16th data bit leaves every register unchanged.
- R5: In a read frame, the addressed register is loaded on the falling edge that follows the last instruction bit. Its bits are then presented most significant first, one per falling edge, and each is valid before the next rising edge.
- R6: In three-pin mode, `sdio_oe_o` is 1 during the data phase of a read frame and 0 during the instruction phase. It returns to 0 within 4 core cycles after the select goes high, and `sdio_o` carries the read bit.
- R7: In four-pin mode, read data appears on `sdo_o` and `sdio_oe_o` stays 0. Bit 0 of register 0 set to 1 selects four-pin mode.
- R8: The mode bit resets to 0 (three-pin mode). A change to it is applied only at the next frame start and stays fixed for the rest of a frame.
- R9: Addresses 8 to 127 (the default `NUM_REGS`=8) are unimplemented. Reads from them return 0, and writes to them change nothing.
- R10: A final rising serial clock edge that arrives in the same core cycle as the select going high still counts, so the write commits.
- R11: After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side |
| sdio_oe_o | output | 1 | Pad output enable for the shared line |
| sdo_o | output | 1 | Dedicated read data pin (four-pin mode) |
| cfg_o | output | NUM_REGS*16 | Register contents, register n at bits [16n+15:16n] |

## Verification
The final rising serial clock edge, which commits a write, can land in the same core cycle as the frame ending on the select line. The bench provokes this by raising the select and the serial clock at the same instant. The overlap is judged correct when the new word appears both in `cfg_o` and in a later four-pin readback. A second overlap occurs when the mode bit is rewritten inside a frame. Here the bench checks that the very next frame already uses the new pin arrangement, and that no frame mixes the two arrangements.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned INSTR_W = 8;
  localparam int unsigned ADDR_W  = INSTR_W - 1;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FRAME_BITS = INSTR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } instr_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_bit_o,
  output logic              rd_phase_o,
  output logic              idle_o
);
  logic              sclk_q, cs_d_q;
  logic              rise, fall, idle;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shin_q, shout_q;
  instr_t            instr_q;
  logic              rd_phase_q;
  logic [DATA_W-1:0] shin_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_d_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_d_q <= cs_s_i;
    end
  end

  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;
  // frame still counts in the cycle the select rises (R10)
  assign idle = cs_s_i & cs_d_q;
  assign shin_next = {shin_q[DATA_W-2:0], sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shin_q  <= '0;
      instr_q <= '0;
    end else if (idle) begin
      cnt_q   <= '0;
      instr_q <= '0;
    end else if (rise && cnt_q < CNT_W'(FRAME_BITS)) begin
      cnt_q  <= cnt_q + 1'b1;
      shin_q <= shin_next;
      if (cnt_q == CNT_W'(INSTR_W - 1)) instr_q <= instr_t'(shin_next[INSTR_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shout_q    <= '0;
      rd_phase_q <= 1'b0;
    end else if (idle) begin
      shout_q    <= '0;
      rd_phase_q <= 1'b0;
    end else if (fall) begin
      if (cnt_q == CNT_W'(INSTR_W) && instr_q.rd) begin
        shout_q    <= rdata_i;
        rd_phase_q <= 1'b1;
      end else if (rd_phase_q && cnt_q < CNT_W'(FRAME_BITS)) begin
        shout_q <= {shout_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign wr_en_o    = ~idle & rise & ~instr_q.rd & (cnt_q == CNT_W'(FRAME_BITS - 1));
  assign wdata_o    = shin_next;
  assign addr_o     = instr_q.addr;
  assign rd_bit_o   = shout_q[DATA_W-1];
  assign rd_phase_o = rd_phase_q;
  assign idle_o     = idle;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS));
  assert_commit_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> cnt_q == CNT_W'(FRAME_BITS));
  assert_read_only_on_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_phase_q |-> instr_q.rd);
  assert_idle_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> (cnt_q == '0 && !rd_phase_q));
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reg_q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(g)) reg_q <= wdata_i;
    end
    assign regs[g] = reg_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs[i];
  end

  assign regs_o = regs;

  assert_hold_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs));
  assert_unimpl_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) >= NUM_REGS) |=> $stable(regs));
endmodule

// File: rtl/srp_port.sv
module srp_port
  import srp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned MODE_REG = 0,
  parameter int unsigned MODE_BIT = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic                       sdo_o,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  localparam int unsigned MODE_IDX = MODE_REG * DATA_W + MODE_BIT;

  logic              sclk_s, cs_s, sdi_s;
  logic [ADDR_W-1:0] addr;
  logic              wr_en, rd_bit, rd_phase, idle;
  logic [DATA_W-1:0] wdata, rdata;
  logic              four_pin_q;

  srp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, sdio_i}),
    .q_o    ({sclk_s, cs_s, sdi_s})
  );

  srp_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .cs_s_i     (cs_s),
    .sdi_s_i    (sdi_s),
    .rdata_i    (rdata),
    .addr_o     (addr),
    .wr_en_o    (wr_en),
    .wdata_o    (wdata),
    .rd_bit_o   (rd_bit),
    .rd_phase_o (rd_phase),
    .idle_o     (idle)
  );

  srp_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .regs_o  (cfg_o)
  );

  // pin mode frozen for the whole frame (R8)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   four_pin_q <= 1'b0;
    else if (idle) four_pin_q <= cfg_o[MODE_IDX];
  end

  assign sdio_oe_o = rd_phase & ~four_pin_q & ~cs_s;
  assign sdio_o    = rd_phase & ~four_pin_q & rd_bit;
  assign sdo_o     = rd_phase &  four_pin_q & rd_bit;

  assert_mode_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable(four_pin_q));
  assert_split_pins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_o));
  assert_oe_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s) |-> !sdio_oe_o);
  assert_oe_only_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> rd_phase);
endmodule

// File: tb/srp_port_test.sv
module srp_port_test;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o;
  logic [NREG*16-1:0] cfg;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] got_dio, got_sdo;
  int oe_instr, oe_data, oe_after;

  always #2.5 clk = ~clk;

  srp_port #(.NUM_REGS(NREG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    logic [15:0] p;
    p = 16'((a + 1) * 16'h0911) ^ 16'hA5C3;
    if (a == 0) p[0] = 1'b0;
    return p;
  endfunction

  task automatic frame(input logic rd, input logic [6:0] a, input logic [15:0] wd,
                       input int nbits, input bit coincide);
    logic [23:0] bits;
    bits = {rd, a, wd};
    got_dio = '0; got_sdo = '0; oe_instr = 0; oe_data = 0; oe_after = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[23-i];
      repeat (4) @(negedge clk);
      if (i < 8) oe_instr += int'(sdio_oe_o);
      else begin
        got_dio[23-i] = sdio_o;
        got_sdo[23-i] = sdo_o;
        oe_data += int'(sdio_oe_o);
      end
      sclk = 1'b1;
      if (coincide && i == nbits - 1) cs_n = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    oe_after = int'(sdio_oe_o) + int'(sdo_o);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R11 / R1 reset state
    chk("R11 regs after reset", {16'h0, 16'(cfg != '0)}, 32'h0);
    chk("R1 oe idle", {31'h0, sdio_oe_o}, 32'h0);
    chk("R1 sdo idle", {31'h0, sdo_o}, 32'h0);

    // R2 R3 R9: write every address
    for (int a = 0; a < 128; a++) frame(1'b0, 7'(a), pat(a), 24, 0);
    for (int a = 0; a < NREG; a++) chk("R3 write stored", {16'h0, cfg[a*16 +: 16]}, {16'h0, pat(a)});

    // R5 R6 R9: three-pin readback of every address
    for (int a = 0; a < 128; a++) begin
      logic [15:0] e;
      e = (a < NREG) ? pat(a) : 16'h0;
      frame(1'b1, 7'(a), 16'hFFFF, 24, 0);
      chk(a < NREG ? "R5 read data" : "R9 unimpl read zero", {16'h0, got_dio}, {16'h0, e});
      chk("R6 oe in data phase", oe_data, 16);
      chk("R6 oe low in instr", oe_instr, 0);
      chk("R6 oe released", oe_after, 0);
      chk("R7 sdo quiet in three-pin", {16'h0, got_sdo}, 32'h0);
    end
    // R2: read frames with all-ones data changed nothing
    for (int a = 0; a < NREG; a++) chk("R2 read keeps reg", {16'h0, cfg[a*16 +: 16]}, {16'h0, pat(a)});

    // R4: short write frames
    frame(1'b0, 7'd3, 16'h1234, 18, 0);
    chk("R4 short by 6 bits", {16'h0, cfg[3*16 +: 16]}, {16'h0, pat(3)});
    frame(1'b0, 7'd3, 16'h1234, 23, 0);
    chk("R4 short by 1 bit", {16'h0, cfg[3*16 +: 16]}, {16'h0, pat(3)});

    // R7 R8: select four-pin, next frame uses it
    frame(1'b0, 7'd0, 16'h0001, 24, 0);
    chk("R8 mode bit written", {16'h0, cfg[15:0]}, 32'h0001);
    frame(1'b1, 7'd5, 16'h0000, 24, 0);
    chk("R7 four-pin data on sdo", {16'h0, got_sdo}, {16'h0, pat(5)});
    chk("R7 oe held low", oe_data + oe_instr, 0);
    chk("R7 sdio quiet", {16'h0, got_dio}, 32'h0);
    chk("R7 sdo released", oe_after, 0);

    // R10: final edge coincident with deselect
    frame(1'b0, 7'd6, 16'hC3A5, 24, 1);
    chk("R10 coincident commit", {16'h0, cfg[6*16 +: 16]}, 32'hC3A5);
    frame(1'b1, 7'd6, 16'h0000, 24, 0);
    chk("R10 coincident readback", {16'h0, got_sdo}, 32'hC3A5);

    // R9 four-pin unimplemented read and write
    frame(1'b0, 7'h7F, 16'hBEEF, 24, 0);
    frame(1'b1, 7'h7F, 16'h0000, 24, 0);
    chk("R9 unimpl read four-pin", {16'h0, got_sdo}, 32'h0);
    chk("R9 regs untouched", {16'h0, cfg[6*16 +: 16]}, 32'hC3A5);

    // R8: back to three-pin from a four-pin frame
    frame(1'b0, 7'd0, 16'h8000, 24, 0);
    frame(1'b1, 7'd2, 16'h0000, 24, 0);
    chk("R8 back to three-pin data", {16'h0, got_dio}, {16'h0, pat(2)});
    chk("R8 back to three-pin oe", oe_data, 16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule